// File: doc/BRIEF.md
# Banked Register File with Common Flags

This block is the general register store of a small 8-bit soft processor core. It holds two complete banks of sixteen 8-bit registers. A bank-select command decides which bank is current, and every register read and write goes to that bank. The core's decoder supplies a 4-bit register index to each of two combinational read ports. Results come back through one synchronous write port.

The block also holds one status flag set: zero, carry and interrupt-enable. Both banks share this flag set, so a bank change never alters it. The usual use is interrupt entry and exit. The handler switches to the second bank and works in registers of its own, so the main program's registers need not be saved. The flags stay as one copy that both contexts see.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, the current bank becomes bank A (`cur_bank` = 0) and all three flags become 0.
- R2: Each bank has sixteen 8-bit registers, selected by a 4-bit index. When `wr_en` is high at a rising edge, `wr_data` is stored at `wr_idx` in the current bank. When `wr_en` is low, no register changes.
- R3: When `bank_cmd` is high at a rising edge, the current bank takes the value of `bank_pick` (0 = bank A, 1 = bank B). When `bank_cmd` is low, the current bank holds. The current bank is shown on `cur_bank`.
- R4: Both read ports return the addressed register of the current bank combinationally, with no clock edge in between.
- R5: The banks are separate. A write to an index in one bank leaves the same index in the other bank unchanged.
- R6: There is exactly one flag set. When `flag_we` is high at a rising edge, `flag_in` is loaded into it. When `flag_we` is low, it holds. The bit positions are 0 = zero, 1 = carry, 2 = interrupt-enable.
- R7: A bank-select command never changes the flags.
- R8: When `bank_cmd` and `wr_en` are both high in the same cycle, the write goes to the bank that was current before the switch.
- R9: A read port that addresses the register being written returns the old value until the clock edge. It returns the new value after the edge.
- R10: The two read ports can address different registers in the same cycle, and each returns its own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 8 | Read port A data (current bank) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 8 | Read port B data (current bank) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 8 | Write data |
| bank_cmd | input | 1 | Bank-select command strobe |
| bank_pick | input | 1 | Bank to select: 0 = A, 1 = B |
| cur_bank | output | 1 | Current bank |
| flag_we | input | 1 | Flag load strobe |
| flag_in | input | 3 | New flags {int-enable, carry, zero} |
| flags | output | 3 | Flags {int-enable, carry, zero} |

## Verification
The assertions assume that every control input (`wr_en`, `bank_cmd`, `flag_we`, `rst`) is 0 or 1, never unknown, at each rising edge. The read-stability property also assumes that a read index that stays the same across two edges was not changed in between. The bench drives every input just after a rising edge and holds it for the whole cycle. Before it compares any read data, it writes each register it reads, so no check depends on the power-up contents of the storage.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int BANK_W  = 1;
  localparam int FLAG_W  = 3;

  typedef struct packed {
    logic int_en;
    logic carry;
    logic zero;
  } brf_flags_t;

  localparam brf_flags_t FLAGS_CLEAR = '{int_en: 1'b0, carry: 1'b0, zero: 1'b0};
endpackage

// File: rtl/brf_bank_ctrl.sv
module brf_bank_ctrl #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd,
  input  logic [BANK_W-1:0] pick,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst)      bank_q <= '0;
    else if (cmd) bank_q <= pick;
  end

  assign bank = bank_q;

  AST_BANK_RESET: assert property (@(posedge clk) rst |=> bank == '0); // R1
  AST_BANK_LOAD:  assert property (@(posedge clk) disable iff (rst)
                    cmd |=> bank == $past(pick)); // R3
  AST_BANK_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !cmd |=> $stable(bank)); // R3
endmodule

// File: rtl/brf_flags.sv
module brf_flags
  import brf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  brf_flags_t din,
  output brf_flags_t dout
);
  brf_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (rst)     flags_q <= FLAGS_CLEAR;
    else if (we) flags_q <= din;
  end

  assign dout = flags_q;

  AST_FLAG_RESET: assert property (@(posedge clk) rst |=> dout == FLAGS_CLEAR); // R1
  AST_FLAG_LOAD:  assert property (@(posedge clk) disable iff (rst)
                    we |=> dout == $past(din)); // R6
  AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !we |=> $stable(dout)); // R6
endmodule

// File: rtl/brf_storage.sv
module brf_storage #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int BANK_W   = 1,
  parameter int RD_PORTS = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [BANK_W-1:0]                 bank,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data
);
  localparam int ADDR_W = BANK_W + IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] waddr;

  assign waddr = {bank, wr_idx};

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [ADDR_W-1:0] raddr;
    assign raddr      = {bank, rd_idx[p]};
    assign rd_data[p] = mem[raddr];
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
                  wr_en |=> mem[$past(waddr)] == $past(wr_data)); // R2
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bank_cmd,
  input  logic [BANK_W-1:0] bank_pick,
  output logic [BANK_W-1:0] cur_bank,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [FLAG_W-1:0] flags
);
  localparam int RD_PORTS = 2;

  logic [BANK_W-1:0]                 bank_w;
  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx_w;
  logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data_w;
  brf_flags_t                        flags_w;

  brf_bank_ctrl #(.BANK_W(BANK_W)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .cmd  (bank_cmd),
    .pick (bank_pick),
    .bank (bank_w)
  );

  assign rd_idx_w = {rd_b_idx, rd_a_idx};

  brf_storage #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .BANK_W   (BANK_W),
    .RD_PORTS (RD_PORTS)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .bank    (bank_w),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx_w),
    .rd_data (rd_data_w)
  );

  brf_flags u_flags (
    .clk  (clk),
    .rst  (rst),
    .we   (flag_we),
    .din  (brf_flags_t'(flag_in)),
    .dout (flags_w)
  );

  assign rd_a_data = rd_data_w[0];
  assign rd_b_data = rd_data_w[1];
  assign cur_bank  = bank_w;
  assign flags     = flags_w;

  AST_BANK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
                          (bank_cmd && !flag_we) |=> $stable(flags)); // R7
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
                     (!wr_en && !bank_cmd) ##1 $stable(rd_a_idx) |-> $stable(rd_a_data)); // R4
  AST_SAME_PORT_AGREE: assert property (@(posedge clk) disable iff (rst)
                         (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data)); // R10
endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/100ps
module tb_banked_regfile;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0] rd_a_data, rd_b_data, wr_data;
  logic       wr_en, bank_cmd, flag_we;
  logic [0:0] bank_pick, cur_bank;
  logic [2:0] flag_in, flags;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bank_cmd(bank_cmd), .bank_pick(bank_pick), .cur_bank(cur_bank),
    .flag_we(flag_we), .flag_in(flag_in), .flags(flags)
  );

  // vector: {bank, index, data}
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 4'h0, 8'h11}, {1'b0, 4'h5, 8'hA5}, {1'b0, 4'hF, 8'hFF},
    {1'b0, 4'h7, 8'h00}, {1'b1, 4'h5, 8'h5A}, {1'b1, 4'h0, 8'hEE},
    {1'b1, 4'hF, 8'h01}, {1'b1, 4'h7, 8'h80}, {1'b0, 4'h9, 8'h3C},
    {1'b1, 4'h9, 8'hC3}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pick_bank(logic b);
    bank_cmd = 1'b1; bank_pick = b; tick(); bank_cmd = 1'b0;
  endtask

  task automatic wr(logic [3:0] i, logic [7:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; bank_cmd = 0; flag_we = 0; bank_pick = 0;
    flag_in = 0; wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
    #1; tick(); tick(); rst = 1'b0;
    check("R1 bank", {7'd0, cur_bank}, 8'd0);
    check("R1 flags", {5'd0, flags}, 8'd0);

    // table walk: write all, then read back from each bank (R2 R3 R5)
    for (int k = 0; k < 10; k++) begin
      pick_bank(VEC[k][12]);
      check("R3 select", {7'd0, cur_bank}, {7'd0, VEC[k][12]});
      wr(VEC[k][11:8], VEC[k][7:0]);
    end
    for (int k = 0; k < 10; k++) begin
      pick_bank(VEC[k][12]);
      rd_a_idx = VEC[k][11:8]; #1;
      check("R2 R5 readback", rd_a_data, VEC[k][7:0]);
    end

    // R10: two ports, different registers of bank B
    pick_bank(1'b1);
    rd_a_idx = 4'h0; rd_b_idx = 4'hF; #1;
    check("R10 port A", rd_a_data, 8'hEE);
    check("R10 port B", rd_b_data, 8'h01);

    // R4: switching bank alone changes read data combinationally
    rd_a_idx = 4'h5; #1;
    check("R4 bank B view", rd_a_data, 8'h5A);
    pick_bank(1'b0); #1;
    check("R4 bank A view", rd_a_data, 8'hA5);

    // R2: wr_en low does not write
    wr_en = 1'b0; wr_idx = 4'h5; wr_data = 8'h77; tick(); #1;
    check("R2 no write", rd_a_data, 8'hA5);

    // R9: old value before edge, new after
    wr_en = 1'b1; wr_idx = 4'h5; wr_data = 8'h99; rd_a_idx = 4'h5; #1;
    check("R9 old before edge", rd_a_data, 8'hA5);
    tick(); wr_en = 1'b0; #1;
    check("R9 new after edge", rd_a_data, 8'h99);

    // R8: switch to B and write in same cycle -> lands in A
    bank_cmd = 1'b1; bank_pick = 1'b1;
    wr_en = 1'b1; wr_idx = 4'h7; wr_data = 8'h42;
    tick(); bank_cmd = 1'b0; wr_en = 1'b0;
    rd_a_idx = 4'h7; #1;
    check("R8 bank B untouched", rd_a_data, 8'h80);
    pick_bank(1'b0); #1;
    check("R8 bank A written", rd_a_data, 8'h42);

    // R6: flag load and hold
    flag_we = 1'b1; flag_in = 3'b101; tick(); flag_we = 1'b0;
    check("R6 load", {5'd0, flags}, 8'h05);
    flag_in = 3'b010; tick();
    check("R6 hold", {5'd0, flags}, 8'h05);

    // R7: bank switches do not touch flags
    pick_bank(1'b1);
    check("R7 after to B", {5'd0, flags}, 8'h05);
    pick_bank(1'b0);
    check("R7 after to A", {5'd0, flags}, 8'h05);

    // R1: reset again from non-reset state
    pick_bank(1'b1);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 rereset bank", {7'd0, cur_bank}, 8'd0);
    check("R1 rereset flags", {5'd0, flags}, 8'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule